// File: doc/BRIEF.md
# GF(8) Generator-Matrix Encoder

This block encodes a message of K symbols over GF(8) into an N-symbol codeword by multiplying the message by a fixed K x N generator matrix. Symbols cross the ports in label form. Multiplication is done by adding exponents. Partial products are converted to their 3-bit polynomial vector form and summed by XOR into a bank of N accumulators.

The generator matrix comes from a constant function of row and column, so no memory has to be loaded. Each accepted message symbol processes one whole generator row in a single cycle: all N columns are multiplied and accumulated in parallel.

A start pulse opens a frame. The next K cycles with message valid high deliver the message symbols in order, and gaps between them are allowed. After the K-th symbol, the codeword streams out one symbol per cycle in index order, with a done flag on the final symbol.

Top module: `nb_gen_encoder`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, cw_vld_o and cw_done_o are low.
- R2: Label L=0 is the field zero and label L=1..7 is alpha^(L-1), with alpha a root of x^3+x+1. Codeword symbol j equals the GF(8) sum over i of m_i * G[i][j].
- R3: Generator entry G[r][c] has label (3r + 5c + 1) mod 8.
- R4: After start_i is sampled high while idle, the next K cycles with msg_vld_i high deliver m_0..m_{K-1} in order. Cycles with msg_vld_i low between them are skipped.
- R5: A zero message symbol, or a zero generator entry, adds nothing to the codeword. An all-zero message gives an all-zero codeword.
- R6: The first row of a frame overwrites the accumulators, so nothing from an earlier frame reaches the new codeword.
- R7: cw_vld_o rises in the cycle after the K-th symbol is accepted. It then stays high for exactly N consecutive cycles and carries symbols 0..N-1 in index order.
- R8: cw_done_o is high only together with the last (N-1) codeword symbol.
- R9: start_i is ignored while a frame is loading or emitting. msg_vld_i is ignored while idle and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a frame when idle |
| msg_vld_i | input | 1 | Message symbol present |
| msg_sym_i | input | 3 | Message symbol, label form |
| cw_vld_o | output | 1 | Codeword symbol valid |
| cw_sym_o | output | 3 | Codeword symbol, label form |
| cw_done_o | output | 1 | Last codeword symbol |

## Verification
The bench builds the block with K=4 and N=8. With these values a frame takes only a dozen cycles, so several hundred frames can be run. The column coefficients of 5c reach every non-zero residue mod 8 across the eight columns, so both the zero generator entries and all seven non-zero labels are used. Unit messages expose single generator rows directly. Random gaps and stray start pulses exercise the accept and ignore paths.

// File: rtl/nbenc_pkg.sv
package nbenc_pkg;
  localparam int SYM_W = 3;

  // multiply a vector by alpha under x^3+x+1, e times
  function automatic logic [SYM_W-1:0] exp_to_vec(input logic [SYM_W-1:0] e);
    logic [SYM_W-1:0] v;
    v = 3'b001;
    for (int i = 0; i < 7; i++) begin
      if (i < int'(e)) v = {v[1:0], 1'b0} ^ {1'b0, v[2], v[2]};
    end
    return v;
  endfunction

  function automatic logic [SYM_W-1:0] vec_to_label(input logic [SYM_W-1:0] v);
    logic [SYM_W-1:0] lbl;
    lbl = '0;
    for (int e = 0; e < 7; e++) begin
      if (exp_to_vec(3'(e)) == v) lbl = 3'(e + 1);
    end
    return lbl;
  endfunction

  // product of two labels, returned in vector form
  function automatic logic [SYM_W-1:0] label_mul_vec(input logic [SYM_W-1:0] a,
                                                     input logic [SYM_W-1:0] b);
    logic [3:0] e;
    if (a == '0 || b == '0) return '0;
    e = {1'b0, a - 3'd1} + {1'b0, b - 3'd1};
    if (e >= 4'd7) e = e - 4'd7;
    return exp_to_vec(e[2:0]);
  endfunction

  function automatic logic [SYM_W-1:0] gen_entry(input int r, input int c);
    return 3'((3 * r + 5 * c + 1) % 8);
  endfunction
endpackage

// File: rtl/nbenc_ctrl.sv
module nbenc_ctrl #(
  parameter int K = 4,
  parameter int N = 8,
  localparam int ROW_W = (K > 1) ? $clog2(K) : 1,
  localparam int COL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             msg_vld_i,
  output logic             acc_en_o,
  output logic             first_o,
  output logic [ROW_W-1:0] row_o,
  output logic             emit_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_EMIT} st_e;

  st_e              state_q, state_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             row_en, col_en;

  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    col_d   = col_q;
    row_en  = 1'b0;
    col_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_LOAD;
          row_d   = '0;
          row_en  = 1'b1;
        end
      end
      ST_LOAD: begin
        if (msg_vld_i) begin
          row_en = 1'b1;
          if (row_q == ROW_W'(K - 1)) begin
            state_d = ST_EMIT;
            row_d   = '0;
            col_d   = '0;
            col_en  = 1'b1;
          end else begin
            row_d = row_q + ROW_W'(1);
          end
        end
      end
      ST_EMIT: begin
        col_en = 1'b1;
        if (col_q == COL_W'(N - 1)) begin
          state_d = ST_IDLE;
          col_d   = '0;
        end else begin
          col_d = col_q + COL_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      state_q <= state_d;
      if (row_en) row_q <= row_d;
      if (col_en) col_q <= col_d;
    end
  end

  assign acc_en_o = (state_q == ST_LOAD) && msg_vld_i;
  assign first_o  = (row_q == '0);
  assign row_o    = row_q;
  assign emit_o   = (state_q == ST_EMIT);
  assign col_o    = col_q;
  assign last_o   = (col_q == COL_W'(N - 1));
endmodule

// File: rtl/nbenc_rowmul.sv
module nbenc_rowmul
  import nbenc_pkg::*;
#(
  parameter int K = 4,
  parameter int N = 8,
  localparam int ROW_W = (K > 1) ? $clog2(K) : 1
) (
  input  logic [ROW_W-1:0]   row_i,
  input  logic [SYM_W-1:0]   sym_i,
  output logic [N*SYM_W-1:0] prod_o
);
  for (genvar c = 0; c < N; c++) begin : g_col
    logic [SYM_W-1:0] coef;
    assign coef = gen_entry(int'(row_i), c);
    assign prod_o[c*SYM_W +: SYM_W] = label_mul_vec(coef, sym_i);
  end
endmodule

// File: rtl/nbenc_accbank.sv
module nbenc_accbank
  import nbenc_pkg::*;
#(
  parameter int N = 8,
  localparam int COL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               first_i,
  input  logic [N*SYM_W-1:0] prod_i,
  input  logic [COL_W-1:0]   col_i,
  output logic [SYM_W-1:0]   vec_o
);
  logic [SYM_W-1:0] acc_q [N];

  for (genvar c = 0; c < N; c++) begin : g_acc
    logic [SYM_W-1:0] acc_d;
    assign acc_d = first_i ? prod_i[c*SYM_W +: SYM_W]
                           : (acc_q[c] ^ prod_i[c*SYM_W +: SYM_W]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc_q[c] <= '0;
      else if (en_i) acc_q[c] <= acc_d;
    end
  end

  assign vec_o = acc_q[col_i];
endmodule

// File: rtl/nb_gen_encoder.sv
module nb_gen_encoder
  import nbenc_pkg::*;
#(
  parameter int K = 4,
  parameter int N = 8,
  localparam int ROW_W = (K > 1) ? $clog2(K) : 1,
  localparam int COL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             msg_vld_i,
  input  logic [SYM_W-1:0] msg_sym_i,
  output logic             cw_vld_o,
  output logic [SYM_W-1:0] cw_sym_o,
  output logic             cw_done_o
);
  logic             rst_meta_q, rst_sync_q;
  logic             acc_en, first_row, emit, last;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [N*SYM_W-1:0] prod;
  logic [SYM_W-1:0] acc_vec;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  nbenc_ctrl #(.K(K), .N(N)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .start_i  (start_i),
    .msg_vld_i(msg_vld_i),
    .acc_en_o (acc_en),
    .first_o  (first_row),
    .row_o    (row),
    .emit_o   (emit),
    .col_o    (col),
    .last_o   (last)
  );

  nbenc_rowmul #(.K(K), .N(N)) u_rowmul (
    .row_i (row),
    .sym_i (msg_sym_i),
    .prod_o(prod)
  );

  nbenc_accbank #(.N(N)) u_acc (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .en_i   (acc_en),
    .first_i(first_row),
    .prod_i (prod),
    .col_i  (col),
    .vec_o  (acc_vec)
  );

  assign cw_vld_o  = emit;
  assign cw_sym_o  = vec_to_label(acc_vec);
  assign cw_done_o = emit && last;
endmodule

// File: rtl/nbenc_chk.sv
module nbenc_chk #(
  parameter int N = 8
) (
  input logic clk,
  input logic rst_n,
  input logic msg_vld_i,
  input logic cw_vld_o,
  input logic cw_done_o
);
  int run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= 0;
    else if (cw_vld_o) run_q <= run_q + 1;
    else               run_q <= 0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!cw_vld_o && !cw_done_o));

  // R8
  done_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_done_o |-> cw_vld_o);

  // R7
  stream_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_vld_o && !cw_done_o) |=> cw_vld_o);

  // R8
  stream_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_done_o |=> !cw_vld_o);

  // R7
  emit_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cw_vld_o) |-> $past(msg_vld_i));

  // R8
  done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_done_o |-> (run_q == N - 1));
endmodule

bind nb_gen_encoder nbenc_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .msg_vld_i(msg_vld_i),
  .cw_vld_o (cw_vld_o),
  .cw_done_o(cw_done_o)
);

// File: tb/nb_gen_encoder_tb.sv
`timescale 1ns/1ps
module nb_gen_encoder_tb;
  localparam int K = 4;
  localparam int N = 8;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic       msg_vld_i;
  logic [2:0] msg_sym_i;
  logic       cw_vld_o;
  logic [2:0] cw_sym_o;
  logic       cw_done_o;

  int  n_chk;
  int  n_fail;
  bit  finished;

  nb_gen_encoder #(.K(K), .N(N)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .msg_vld_i(msg_vld_i),
    .msg_sym_i(msg_sym_i),
    .cw_vld_o (cw_vld_o),
    .cw_sym_o (cw_sym_o),
    .cw_done_o(cw_done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // vector form of alpha^e, e = 0..6, under x^3+x+1 (R2)
  function automatic logic [2:0] t_pow(input int e);
    logic [2:0] tbl [7] = '{3'd1, 3'd2, 3'd4, 3'd3, 3'd6, 3'd7, 3'd5};
    return tbl[e % 7];
  endfunction

  function automatic logic [2:0] t_mul(input logic [2:0] a, input logic [2:0] b);
    if (a == 0 || b == 0) return 3'd0;
    return t_pow(int'(a) - 1 + int'(b) - 1);
  endfunction

  function automatic logic [2:0] t_lbl(input logic [2:0] v);
    for (int e = 0; e < 7; e++) if (t_pow(e) == v) return 3'(e + 1);
    return 3'd0;
  endfunction

  // R3 generator entry
  function automatic logic [2:0] t_gen(input int r, input int c);
    return 3'((3 * r + 5 * c + 1) % 8);
  endfunction

  function automatic logic [2:0] t_code(input logic [2:0] m [K], input int c);
    logic [2:0] acc = 3'd0;
    for (int r = 0; r < K; r++) acc = acc ^ t_mul(m[r], t_gen(r, c));
    return t_lbl(acc);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one frame; poke drives stray start pulses during load gaps and emission (R9)
  task automatic run_frame(input logic [2:0] m [K], input int gap_max,
                           input bit poke, input string req);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int r = 0; r < K; r++) begin
      int gaps = (gap_max > 0) ? int'($urandom_range(gap_max)) : 0;
      for (int g = 0; g < gaps; g++) begin
        start_i   = poke;
        msg_sym_i = 3'($urandom);
        check(cw_vld_o == 1'b0, "R4 no output during load", cw_vld_o, 0);
        @(negedge clk);
        start_i = 1'b0;
      end
      msg_vld_i = 1'b1;
      msg_sym_i = m[r];
      @(negedge clk);
      msg_vld_i = 1'b0;
      msg_sym_i = 3'($urandom);
    end
    for (int c = 0; c < N; c++) begin
      logic [2:0] exp_sym = t_code(m, c);
      check(cw_vld_o == 1'b1, {req, " R7 valid"}, cw_vld_o, 1);
      check(cw_sym_o == exp_sym, {req, " R2 symbol"}, cw_sym_o, exp_sym);
      check(cw_done_o == (c == N - 1), "R8 done flag", cw_done_o, (c == N - 1));
      start_i = poke && (c == 2);
      @(negedge clk);
      start_i = 1'b0;
    end
    check(cw_vld_o == 1'b0, "R7 stream length", cw_vld_o, 0);
  endtask

  initial begin
    logic [2:0] m [K];
    int unused_seed;
    n_chk     = 0;
    n_fail    = 0;
    finished  = 1'b0;
    start_i   = 1'b0;
    msg_vld_i = 1'b0;
    msg_sym_i = 3'd0;
    rst_n     = 1'b0;
    unused_seed = int'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1
    check(cw_vld_o == 1'b0, "R1 valid in reset", cw_vld_o, 0);
    check(cw_done_o == 1'b0, "R1 done in reset", cw_done_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cw_vld_o == 1'b0, "R1 valid after reset", cw_vld_o, 0);

    // R5 all-zero message
    for (int r = 0; r < K; r++) m[r] = 3'd0;
    run_frame(m, 0, 1'b0, "R5 zero msg");

    // R3 unit messages expose single rows, scaled
    for (int r = 0; r < K; r++) begin
      for (int i = 0; i < K; i++) m[i] = 3'd0;
      m[r] = 3'd1;
      run_frame(m, 0, 1'b0, "R3 unit row");
      m[r] = 3'd7;
      run_frame(m, 1, 1'b0, "R5 single nonzero");
    end

    // R6 back-to-back after a full frame, first row zero
    for (int r = 0; r < K; r++) m[r] = 3'd6;
    run_frame(m, 0, 1'b0, "R6 prior frame");
    m[0] = 3'd0; m[1] = 3'd0; m[2] = 3'd3; m[3] = 3'd0;
    run_frame(m, 0, 1'b0, "R6 overwrite");

    // R9 stray start pulses inside a frame
    for (int r = 0; r < K; r++) m[r] = 3'(r + 2);
    run_frame(m, 3, 1'b1, "R9 start ignored");

    // R9 msg_vld while idle: no output
    for (int i = 0; i < K + N; i++) begin
      msg_vld_i = 1'b1;
      msg_sym_i = 3'($urandom);
      @(negedge clk);
      check(cw_vld_o == 1'b0, "R9 idle msg ignored", cw_vld_o, 0);
    end
    msg_vld_i = 1'b0;
    for (int r = 0; r < K; r++) m[r] = 3'(r + 1);
    run_frame(m, 0, 1'b0, "R9 after idle msgs");

    // R4 random messages with gaps
    for (int t = 0; t < 300; t++) begin
      for (int r = 0; r < K; r++) m[r] = 3'($urandom);
      run_frame(m, 3, bit'($urandom_range(1)), "R4 random");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule